// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block runs one SPI exchange of a set number of bytes between an 8-bit transmit queue and an 8-bit receive queue. Software loads the transmit queue, programs two lengths, picks the clock polarity, clock phase and bit order, and pulses start. The first length is the total number of bytes clocked on the wire. The second is how many of those bytes come from the transmit queue. Once the transmit share is used up, the engine clocks out zero bytes for the rest of the burst, so a short command can be followed by a long read.

Serial clock pacing comes from a separate divider. Its half-period strobe `clk_tick` moves SCLK by one edge. Received bytes go into the receive queue unless discard mode is chosen, which suits write-only transfers. At the end of the burst a sticky completion flag is raised. This flag can drive an interrupt line through an enable, and it is cleared by writing one to it. The chip select is either driven by the engine around the burst or, in manual mode, held at a level chosen by software.

Top module: `spi_burst_engine`

## Requirements
- R1: After an accepted start with burst length N (1..64), exactly N bytes are clocked, which is 16·N SCLK transitions, and the engine then returns to idle.
- R2: The first min(T, N) bytes on MOSI are popped in order from the transmit queue (T = transmit length); every later byte of the burst is 0x00.
- R3: Each byte sampled from MISO is written to the receive queue in order; with discard mode set, nothing is written and the receive level stays unchanged.
- R4: With polarity 0, SCLK idles low; with polarity 1, it idles high. With phase 0, data is sampled on the first edge of each bit. With phase 1, data is sampled on the second edge of each bit, and MOSI changes on the first edge.
- R5: With LSB-first set, bit 0 of each byte is sent and received first; otherwise bit 7 comes first.
- R6: A start with burst length above 64 is ignored: busy stays low, no completion is flagged and the transmit queue is not touched.
- R7: A start with burst length 0 completes at once. It raises the completion flag with no SCLK transition and no chip-select activity.
- R8: Busy reads high from the cycle after an accepted start until completion and then clears by itself. A start while busy has no effect.
- R9: The completion flag is set when the burst ends and holds until a one is written to `tc_clr`; `irq` is the flag gated by `tc_irq_en`.
- R10: A pulse on `txf_reset` empties the transmit queue; a pulse on `rxf_reset` empties the receive queue.
- R11: In manual chip-select mode, `cs_n` follows `cfg_cs_level` one cycle later, whatever the engine is doing. In automatic mode, `cs_n` is low only while bytes are being clocked.
- R12: A transmit length larger than the burst length pops only burst-length bytes; the rest stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_tick | input | 1 | Half-period strobe from the divider; one SCLK edge per strobe |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase (0: sample on first edge) |
| cfg_lsb_first | input | 1 | Bit order, 1 = bit 0 first |
| cfg_discard_rx | input | 1 | Do not store received bytes |
| cfg_cs_manual | input | 1 | Chip select follows `cfg_cs_level` |
| cfg_cs_level | input | 1 | Chip select level used in manual mode |
| start | input | 1 | Start pulse for one burst |
| txf_reset | input | 1 | Empty the transmit queue |
| rxf_reset | input | 1 | Empty the receive queue |
| burst_len | input | 8 | Total bytes in the burst (0..64 accepted) |
| tx_len | input | 8 | Bytes taken from the transmit queue |
| tc_irq_en | input | 1 | Completion interrupt enable |
| tc_clr | input | 1 | Write-one-to-clear of the completion flag |
| tx_wr | input | 1 | Push `tx_wdata` into the transmit queue |
| tx_wdata | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | 7 | Transmit queue fill |
| rx_rd | input | 1 | Pop the receive queue |
| rx_rdata | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 7 | Receive queue fill |
| busy | output | 1 | Burst in progress |
| tc_pending | output | 1 | Completion flag |
| irq | output | 1 | Completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The hardest point to reach is the handover from queued data to zero fill inside one burst. It has to be seen in several clock modes, because in phase 0 the first bit of each byte must already be on MOSI before the first edge. The bench runs a serial slave model that captures MOSI and drives MISO according to its own view of the selected mode and bit order. It programs bursts whose transmit length is shorter than the burst and also longer than it, and compares the captured bytes, the receive queue contents and the leftover transmit level. Restart pulses in mid-burst, oversize and zero lengths, and manual chip select with the line held high are each driven in their own scenario.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int FIFO_DEPTH = 64;
    localparam int DATA_W     = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_SHIFT,
        SEQ_FINISH
    } seq_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic discard_rx;
    } xfer_mode_t;

    // bit position inside a byte for the k-th bit on the wire
    function automatic int lane_of(input logic lsb, input int k, input int width);
        return lsb ? k : (width - 1 - k);
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    logic [DW-1:0]    mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [LVL_W-1:0] cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == LVL_W'(DEPTH));
    assign level   = cnt;
    assign rdata   = mem[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> empty);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !clear) |-> !empty);

endmodule

// File: rtl/spi_tc_status.sv
module spi_tc_status (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic pending_o,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (rst)        pending_o <= 1'b0;
        else if (set_i) pending_o <= 1'b1;
        else if (clr_i) pending_o <= 1'b0;
    end

    assign irq_o = pending_o & en_i;

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pending_o && !clr_i) |=> pending_o);

endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
    import spi_burst_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int LEN_W  = LVL_W + 1,
    localparam int EDGE_W = $clog2(2 * DW),
    localparam int BIT_W  = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [LEN_W-1:0] burst_len,
    input  logic [LEN_W-1:0] tx_len,
    input  xfer_mode_t       mode_in,
    input  logic             cs_manual,
    input  logic             cs_level,
    input  logic             tx_empty,
    input  logic [DW-1:0]    tx_data,
    output logic             tx_pop,
    input  logic             miso,
    output logic             rx_push,
    output logic [DW-1:0]    rx_data,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n
);
    seq_state_e        state;
    xfer_mode_t        mode_q;
    logic [LEN_W-1:0]  bytes_left, tx_left;
    logic [DW-1:0]     cur_byte, rx_byte, rx_next, load_byte;
    logic [EDGE_W-1:0] edge_cnt;
    logic [BIT_W-1:0]  kbit;
    logic              act, idle_pol_q;
    logic              leading, last_edge, sample_now, byte_end, accept;

    assign leading    = !edge_cnt[0];
    assign kbit       = edge_cnt[EDGE_W-1:1];
    assign last_edge  = (edge_cnt == EDGE_W'(2 * DW - 1));
    assign sample_now = tick && (state == SEQ_SHIFT) && (leading ^ mode_q.cpha);
    assign byte_end   = tick && (state == SEQ_SHIFT) && last_edge;
    assign accept     = (state == SEQ_IDLE) && start && (burst_len <= LEN_W'(DEPTH));

    assign tx_pop    = (state == SEQ_LOAD) && (tx_left != '0) && !tx_empty;
    assign load_byte = tx_pop ? tx_data : '0;

    always_comb begin
        rx_next = rx_byte;
        if (sample_now)
            rx_next[BIT_W'(lane_of(mode_q.lsb_first, int'(kbit), DW))] = miso;
    end

    assign rx_data = rx_next;
    assign rx_push = byte_end && !mode_q.discard_rx;
    assign busy    = (state != SEQ_IDLE);
    assign done    = (state == SEQ_FINISH);
    assign sclk    = (state == SEQ_IDLE) ? idle_pol_q : (mode_q.cpol ^ act);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            mode_q     <= '0;
            bytes_left <= '0;
            tx_left    <= '0;
            cur_byte   <= '0;
            rx_byte    <= '0;
            edge_cnt   <= '0;
            act        <= 1'b0;
            mosi       <= 1'b0;
            idle_pol_q <= 1'b0;
            cs_n       <= 1'b1;
        end else begin
            idle_pol_q <= mode_in.cpol;
            cs_n <= cs_manual ? cs_level
                              : !((state == SEQ_LOAD) || (state == SEQ_SHIFT));
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        mode_q     <= mode_in;
                        bytes_left <= burst_len;
                        tx_left    <= (tx_len > burst_len) ? burst_len : tx_len;
                        state      <= (burst_len == '0) ? SEQ_FINISH : SEQ_LOAD;
                    end
                end
                SEQ_LOAD: begin
                    cur_byte <= load_byte;
                    rx_byte  <= '0;
                    edge_cnt <= '0;
                    act      <= 1'b0;
                    if (tx_left != '0) tx_left <= tx_left - 1'b1;
                    if (!mode_q.cpha)
                        mosi <= load_byte[BIT_W'(lane_of(mode_q.lsb_first, 0, DW))];
                    state <= SEQ_SHIFT;
                end
                SEQ_SHIFT: begin
                    if (tick) begin
                        edge_cnt <= edge_cnt + 1'b1;
                        act      <= !act;
                        rx_byte  <= rx_next;
                        if (mode_q.cpha && leading)
                            mosi <= cur_byte[BIT_W'(lane_of(mode_q.lsb_first, int'(kbit), DW))];
                        else if (!mode_q.cpha && !leading && kbit != BIT_W'(DW - 1))
                            mosi <= cur_byte[BIT_W'(lane_of(mode_q.lsb_first, int'(kbit) + 1, DW))];
                        if (last_edge) begin
                            bytes_left <= bytes_left - 1'b1;
                            state <= (bytes_left == LEN_W'(1)) ? SEQ_FINISH : SEQ_LOAD;
                        end
                    end
                end
                default: begin
                    mosi  <= 1'b0;
                    state <= SEQ_IDLE;
                end
            endcase
        end
    end

    // R6
    oversize_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && start && burst_len > LEN_W'(DEPTH)) |=> (state == SEQ_IDLE));

    // R1
    shift_has_work_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_SHIFT) |-> (bytes_left != '0));

    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && state == SEQ_IDLE && $past(state == SEQ_IDLE) && $stable(mode_in.cpol))
            |-> (sclk == mode_in.cpol));

    // R11
    cs_manual_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cs_manual)) |-> (cs_n == $past(cs_level)));

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = FIFO_DEPTH,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int LEN_W = LVL_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_tick,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic             cfg_discard_rx,
    input  logic             cfg_cs_manual,
    input  logic             cfg_cs_level,
    input  logic             start,
    input  logic             txf_reset,
    input  logic             rxf_reset,
    input  logic [LEN_W-1:0] burst_len,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             tc_irq_en,
    input  logic             tc_clr,
    input  logic             tx_wr,
    input  logic [DW-1:0]    tx_wdata,
    output logic             tx_full,
    output logic [LVL_W-1:0] tx_level,
    input  logic             rx_rd,
    output logic [DW-1:0]    rx_rdata,
    output logic             rx_empty,
    output logic [LVL_W-1:0] rx_level,
    output logic             busy,
    output logic             tc_pending,
    output logic             irq,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    xfer_mode_t     mode;
    logic           tx_empty, tx_pop, rx_push, rx_full, seq_done;
    logic [DW-1:0]  tx_head, rx_byte;

    assign mode.cpol       = cfg_cpol;
    assign mode.cpha       = cfg_cpha;
    assign mode.lsb_first  = cfg_lsb_first;
    assign mode.discard_rx = cfg_discard_rx;

    spi_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clear(txf_reset),
        .push(tx_wr), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    spi_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clear(rxf_reset),
        .push(rx_push && !rx_full), .wdata(rx_byte),
        .pop(rx_rd && !rx_empty), .rdata(rx_rdata),
        .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    spi_burst_seq #(.DW(DW), .DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .tick(clk_tick), .start(start),
        .burst_len(burst_len), .tx_len(tx_len), .mode_in(mode),
        .cs_manual(cfg_cs_manual), .cs_level(cfg_cs_level),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .miso(miso), .rx_push(rx_push), .rx_data(rx_byte),
        .busy(busy), .done(seq_done),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    spi_tc_status u_tc (
        .clk(clk), .rst(rst), .set_i(seq_done), .clr_i(tc_clr),
        .en_i(tc_irq_en), .pending_o(tc_pending), .irq_o(irq)
    );

    // R8
    busy_fall_tc_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> tc_pending);

    // R7
    idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cfg_cs_manual && !$past(cfg_cs_manual) && !busy && !$past(busy))
            |-> cs_n);

endmodule

// File: tb/tb_spi_burst_engine.sv
`timescale 1ns/1ps
module tb_spi_burst_engine;
    logic       clk = 1'b0, rst = 1'b1, clk_tick = 1'b0;
    logic       cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_discard_rx = 0;
    logic       cfg_cs_manual = 0, cfg_cs_level = 1;
    logic       start = 0, txf_reset = 0, rxf_reset = 0;
    logic [7:0] burst_len = 0, tx_len = 0;
    logic       tc_irq_en = 0, tc_clr = 0, tx_wr = 0, rx_rd = 0;
    logic [7:0] tx_wdata = 0, rx_rdata;
    logic       tx_full, rx_empty, busy, tc_pending, irq, sclk, mosi, miso, cs_n;
    logic [6:0] tx_level, rx_level;

    spi_burst_engine dut (
        .clk(clk), .rst(rst), .clk_tick(clk_tick),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_discard_rx(cfg_discard_rx), .cfg_cs_manual(cfg_cs_manual),
        .cfg_cs_level(cfg_cs_level), .start(start), .txf_reset(txf_reset),
        .rxf_reset(rxf_reset), .burst_len(burst_len), .tx_len(tx_len),
        .tc_irq_en(tc_irq_en), .tc_clr(tc_clr), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_full(tx_full), .tx_level(tx_level), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .rx_empty(rx_empty), .rx_level(rx_level), .busy(busy), .tc_pending(tc_pending),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            clk_tick = ~clk_tick;
        end
    end

    int n_chk = 0, n_bad = 0, tog = 0, cs_low = 0;
    logic       m_cpol = 0, m_cpha = 0, m_lsb = 0;
    logic [7:0] resp [0:127];
    logic [7:0] cap  [0:127];
    logic [9:0] scnt = '0;
    logic       prev_sclk = 1'b0;

    // slave model: samples MOSI on its sample edge, MISO from its bit count
    always @(sclk or cs_n) begin
        if (cs_n) scnt = '0;
        else if (sclk != prev_sclk && sclk == (m_cpha ? m_cpol : !m_cpol)) begin
            cap[scnt[9:3]][m_lsb ? scnt[2:0] : 3'd7 - scnt[2:0]] = mosi;
            scnt = scnt + 1'b1;
        end
        prev_sclk = sclk;
    end

    assign miso = resp[scnt[9:3]][m_lsb ? scnt[2:0] : 3'd7 - scnt[2:0]];

    always @(sclk) tog++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_wr = 1; tx_wdata = b;
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic set_mode(input logic p, input logic h, input logic l, input logic d);
        cfg_cpol = p; cfg_cpha = h; cfg_lsb_first = l; cfg_discard_rx = d;
        m_cpol = p; m_cpha = h; m_lsb = l;
        cyc(3);
    endtask

    task automatic go(input int n, input int t);
        burst_len = 8'(n); tx_len = 8'(t);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        cs_low = 0;
        while (busy && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (!cs_n) cs_low++;
        end
        if (guard >= 4000) chk("R1", "completion timeout", 0, 1);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        tc_clr = 1; @(negedge clk); tc_clr = 0;
    endtask

    task automatic drain_check(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, $sformatf("rx byte %0d", i), int'(rx_rdata), int'(resp[i]));
            rx_rd = 1; @(negedge clk); rx_rd = 0;
        end
    endtask

    task automatic t_reset();
        chk("R8", "busy after reset", int'(busy), 0);
        chk("R11", "cs_n after reset", int'(cs_n), 1);
        chk("R3", "rx empty after reset", int'(rx_empty), 1);
        chk("R9", "tc after reset", int'(tc_pending), 0);
        chk("R9", "irq after reset", int'(irq), 0);
        chk("R4", "sclk idle cpol0", int'(sclk), 0);
    endtask

    task automatic t_mode0_full();
        int t0;
        set_mode(0, 0, 0, 0);
        tc_irq_en = 1;
        push_tx(8'hA5); push_tx(8'h3C); push_tx(8'hF0); push_tx(8'h01);
        resp[0] = 8'h5A; resp[1] = 8'hC3; resp[2] = 8'h0F; resp[3] = 8'h80;
        t0 = tog;
        go(4, 4);
        chk("R8", "busy after start", int'(busy), 1);
        wait_idle();
        chk("R1", "sclk transitions 4 bytes", tog - t0, 64);
        chk("R11", "auto cs low during burst", int'(cs_low > 0), 1);
        chk("R2", "mosi byte0", int'(cap[0]), 8'hA5);
        chk("R2", "mosi byte3", int'(cap[3]), 8'h01);
        chk("R3", "rx level", int'(rx_level), 4);
        drain_check("R3", 4);
        chk("R9", "tc set", int'(tc_pending), 1);
        chk("R9", "irq enabled", int'(irq), 1);
        chk("R8", "busy self-cleared", int'(busy), 0);
        chk("R11", "cs_n idle", int'(cs_n), 1);
        pulse_clr();
        chk("R9", "tc cleared", int'(tc_pending), 0);
        chk("R9", "irq cleared", int'(irq), 0);
    endtask

    task automatic t_mode3_fill();
        set_mode(1, 1, 0, 0);
        chk("R4", "sclk idle cpol1", int'(sclk), 1);
        push_tx(8'h9E);
        resp[0] = 8'h11; resp[1] = 8'h22; resp[2] = 8'h33;
        go(3, 1);
        wait_idle();
        chk("R2", "mode3 byte0 from queue", int'(cap[0]), 8'h9E);
        chk("R2", "mode3 byte1 zero fill", int'(cap[1]), 0);
        chk("R2", "mode3 byte2 zero fill", int'(cap[2]), 0);
        drain_check("R4", 3);
        chk("R4", "sclk idle after burst", int'(sclk), 1);
        pulse_clr();
    endtask

    task automatic t_lsb(input logic p, input logic h);
        set_mode(p, h, 1, 0);
        push_tx(8'h80); push_tx(8'h03);
        resp[0] = 8'hC1; resp[1] = 8'h2B;
        go(2, 2);
        wait_idle();
        chk("R5", "lsb byte0", int'(cap[0]), 8'h80);
        chk("R5", "lsb byte1", int'(cap[1]), 8'h03);
        drain_check("R5", 2);
        pulse_clr();
    endtask

    task automatic t_discard();
        set_mode(0, 1, 0, 1);
        push_tx(8'h6D); push_tx(8'h72);
        resp[0] = 8'hEE; resp[1] = 8'hDD;
        go(2, 2);
        wait_idle();
        chk("R3", "discard keeps rx empty", int'(rx_level), 0);
        chk("R2", "discard still sends", int'(cap[1]), 8'h72);
        pulse_clr();
    endtask

    task automatic t_zero();
        int t0;
        set_mode(0, 0, 0, 0);
        t0 = tog;
        go(0, 0);
        wait_idle();
        chk("R7", "zero burst no sclk", tog - t0, 0);
        chk("R7", "zero burst no cs", cs_low, 0);
        chk("R7", "zero burst flags done", int'(tc_pending), 1);
        pulse_clr();
    endtask

    task automatic t_oversize_and_resets();
        push_tx(8'h44);
        go(65, 1);
        cyc(3);
        chk("R6", "oversize not busy", int'(busy), 0);
        chk("R6", "oversize no tc", int'(tc_pending), 0);
        chk("R6", "oversize queue untouched", int'(tx_level), 1);
        push_tx(8'h55); push_tx(8'h66); push_tx(8'h77); push_tx(8'h88);
        resp[0] = 8'h01; resp[1] = 8'h02;
        go(2, 5);
        wait_idle();
        chk("R12", "leftover tx bytes", int'(tx_level), 3);
        chk("R12", "second byte sent", int'(cap[1]), 8'h55);
        txf_reset = 1; @(negedge clk); txf_reset = 0;
        chk("R10", "tx queue emptied", int'(tx_level), 0);
        chk("R10", "rx had data", int'(rx_level), 2);
        rxf_reset = 1; @(negedge clk); rxf_reset = 0;
        chk("R10", "rx queue emptied", int'(rx_empty), 1);
        pulse_clr();
    endtask

    task automatic t_manual_cs();
        cfg_cs_manual = 1; cfg_cs_level = 0;
        cyc(2);
        chk("R11", "manual cs low", int'(cs_n), 0);
        cfg_cs_level = 1;
        cyc(2);
        push_tx(8'h12);
        go(1, 1);
        wait_idle();
        chk("R11", "manual cs held high in burst", cs_low, 0);
        chk("R11", "manual burst completes", int'(tc_pending), 1);
        cfg_cs_manual = 0;
        cyc(2);
        chk("R11", "auto cs idle high", int'(cs_n), 1);
        rxf_reset = 1; @(negedge clk); rxf_reset = 0;
        pulse_clr();
    endtask

    task automatic t_restart_ignored();
        int t0;
        set_mode(0, 0, 0, 0);
        push_tx(8'hAB); push_tx(8'hCD);
        resp[0] = 8'h10; resp[1] = 8'h20;
        t0 = tog;
        go(2, 2);
        cyc(10);
        go(2, 2);
        wait_idle();
        chk("R8", "restart adds no bytes", tog - t0, 32);
        cyc(5);
        chk("R8", "stays idle", int'(busy), 0);
        chk("R8", "rx byte count", int'(rx_level), 2);
        rxf_reset = 1; @(negedge clk); rxf_reset = 0;
        pulse_clr();
    endtask

    task automatic t_irq_mask();
        tc_irq_en = 0;
        go(0, 0);
        wait_idle();
        chk("R9", "pending while masked", int'(tc_pending), 1);
        chk("R9", "irq masked", int'(irq), 0);
        tc_irq_en = 1;
        @(negedge clk);
        chk("R9", "irq unmasked", int'(irq), 1);
        cyc(3);
        chk("R9", "flag holds", int'(tc_pending), 1);
        pulse_clr();
        chk("R9", "irq gone after clear", int'(irq), 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin resp[i] = 8'h00; cap[i] = 8'h00; end
        cyc(4);
        rst = 0;
        cyc(2);
        t_reset();
        t_mode0_full();
        t_mode3_fill();
        t_lsb(0, 1);
        t_lsb(1, 0);
        t_discard();
        t_zero();
        t_oversize_and_resets();
        t_manual_cs();
        t_restart_ignored();
        t_irq_mask();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule